// File: doc/BRIEF.md
# Windowed Oscillator Quality Checker

This block judges whether an oscillator is healthy by counting its rising edges inside fixed time windows. Each window is timed by an independent, free-running window clock, so a stopped or sluggish oscillator cannot hold the timer up. A check is launched by a one-cycle trigger pulse. The surrounding logic raises that pulse on power-on reset, on low-voltage reset, on wake from full stop, or when the coarse loss-of-clock monitor reports a failure. The block is a finer companion to that coarse monitor.

Inside a window, oscillator edges cross into the window clock domain through a toggle flop and a two-flop synchronizer. Each toggle that is seen adds one to a counter. When the counter reaches the threshold, the window ends at once and the check passes; the window does not run on to its full length. When a window runs out first, the edge count is thrown away and a fresh window begins. After a set number of unsuccessful windows, the check fails. The number of windows used stays visible after the check ends, until the next trigger.

The default timing is a window of 50000 window-clock cycles, a threshold of 4096 edges and a limit of 50 windows. All three are parameters. The `trigger` input is synchronous to `clk`.

Top module: `osc_quality_checker`

## Requirements
- R1: After reset, `busy`, `osc_ok`, `pass` and `fail` are low and `windows_used` is 0.
- R2: In the cycle after `trigger` is sampled high, `busy` is high and `windows_used` is 1.
- R3: When THRESH rising oscillator edges have been counted within one window, `osc_ok` and `pass` are high together for one cycle and `busy` falls in that same cycle, before the window's full length has elapsed.
- R4: A window lasts exactly WINDOW cycles of `clk`. A window that expires without reaching the threshold clears the edge count, starts the next window and adds one to `windows_used`, which never exceeds MAX_WIN.
- R5: If none of MAX_WIN windows reaches the threshold, `fail` pulses and `busy` falls. At that point `busy` has been high for exactly MAX_WIN*WINDOW cycles and `windows_used` equals MAX_WIN.
- R6: `pass` and `fail` are never high together, and each is high for exactly one cycle.
- R7: A `trigger` that arrives while `busy` is high restarts the check from window one. The full MAX_WIN*WINDOW cycles are counted again from that trigger.
- R8: After a check ends, `windows_used` holds its value until the next trigger.
- R9: Edges do not carry over between windows. An oscillator whose edges per window stay below THRESH fails, even when its total over all windows exceeds THRESH.
- R10: Oscillator edges while `busy` is low have no effect: no pulse appears and `windows_used` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running window clock, independent of the oscillator |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_clk | input | 1 | Oscillator under test |
| trigger | input | 1 | One-cycle start or restart request, synchronous to clk |
| busy | output | 1 | High while a check is running |
| osc_ok | output | 1 | One-cycle pulse when a window reaches the edge threshold |
| pass | output | 1 | One-cycle pulse: the check passed |
| fail | output | 1 | One-cycle pulse: every window expired without reaching the threshold |
| windows_used | output | $clog2(MAX_WIN+1) | Windows started by the current or last check |

## Verification
The checker is driven with oscillator periods drawn at random from two groups: one well above the threshold rate and one well below it. Candidates near the boundary are discarded, so each verdict can be predicted from the period alone. This separates early termination (a pass in window one, inside WINDOW cycles) from the full fail sequence (exactly MAX_WIN*WINDOW busy cycles). Directed cases add a stopped oscillator and a rate that is just below the threshold per window but well above it summed over all windows, which exposes any edge count that survives a window boundary. Further directed cases cover a retrigger midway through the second window, and oscillator activity while idle, which must leave both the pulses and the window count untouched.

// File: rtl/oqc_pkg.sv
`timescale 1ns/1ps
package oqc_pkg;

  // Width needed to hold values 0..n (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // A window is on its last cycle when the cycle index is WINDOW-1.
  function automatic bit window_done(input logic [31:0] idx, input int unsigned window);
    return idx == 32'(window - 1);
  endfunction

  // The threshold is met once the stored count plus the new edge reaches it.
  function automatic bit tally_full(input logic [31:0] cnt, input bit hit, input int unsigned thresh);
    return hit && ((cnt + 32'd1) >= 32'(thresh));
  endfunction

  // The check gives up when the window that just ended was the last allowed one.
  function automatic bit out_of_windows(input logic [31:0] used, input int unsigned max_win);
    return used >= 32'(max_win);
  endfunction

endpackage

// File: rtl/oqc_edge_sync.sv
`timescale 1ns/1ps
module oqc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_clk,
  output logic edge_pulse
);
  logic tgl;
  logic s1, s2, s3;

  // Toggle on every rising oscillator edge, in the oscillator's own domain.
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  // Two-flop synchronizer, plus one flop for change detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tgl;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_pulse = s2 ^ s3;
endmodule

// File: rtl/oqc_window_timer.sv
`timescale 1ns/1ps
module oqc_window_timer #(
  parameter int unsigned WINDOW = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic last
);
  import oqc_pkg::*;
  localparam int unsigned IW = cnt_width(WINDOW);

  logic [IW-1:0] idx;

  assign last = run && window_done(32'(idx), WINDOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (clear)  idx <= '0;
    else if (run)    idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/oqc_edge_tally.sv
`timescale 1ns/1ps
module oqc_edge_tally #(
  parameter int unsigned THRESH = 4096,
  localparam int unsigned CW = oqc_pkg::cnt_width(THRESH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic          edge_in,
  output logic          reach,
  output logic [CW-1:0] count
);
  import oqc_pkg::*;

  assign reach = run && tally_full(32'(count), edge_in, THRESH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         count <= '0;
    else if (clear)                     count <= '0;
    else if (run && edge_in && !reach)  count <= count + 1'b1;
  end
endmodule

// File: rtl/osc_quality_checker.sv
`timescale 1ns/1ps
module osc_quality_checker #(
  parameter int unsigned WINDOW  = 50000,
  parameter int unsigned THRESH  = 4096,
  parameter int unsigned MAX_WIN = 50,
  localparam int unsigned WUW = oqc_pkg::cnt_width(MAX_WIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           osc_clk,
  input  logic           trigger,
  output logic           busy,
  output logic           osc_ok,
  output logic           pass,
  output logic           fail,
  output logic [WUW-1:0] windows_used
);
  import oqc_pkg::*;
  localparam int unsigned CW = cnt_width(THRESH);

  // Named internal events, visible to the bound checker.
  logic          osc_edge;
  logic          seg_run;
  logic          seg_clear;
  logic          win_last;
  logic          tally_reach;
  logic          win_expire;
  logic          final_win;
  logic          give_up;
  logic [CW-1:0] edge_count;

  assign seg_run    = busy && !trigger;
  assign win_expire = win_last && !tally_reach;
  assign final_win  = out_of_windows(32'(windows_used), MAX_WIN);
  assign give_up    = win_expire && final_win;
  assign seg_clear  = trigger || win_expire;

  oqc_edge_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_clk    (osc_clk),
    .edge_pulse (osc_edge)
  );

  oqc_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (seg_clear),
    .run   (seg_run),
    .last  (win_last)
  );

  oqc_edge_tally #(.THRESH(THRESH)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (seg_clear),
    .run     (seg_run),
    .edge_in (osc_edge),
    .reach   (tally_reach),
    .count   (edge_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      osc_ok       <= 1'b0;
      pass         <= 1'b0;
      fail         <= 1'b0;
      windows_used <= '0;
    end else begin
      osc_ok <= tally_reach;
      pass   <= tally_reach;
      fail   <= give_up;
      if (trigger) begin
        busy         <= 1'b1;
        windows_used <= WUW'(1);
      end else if (tally_reach || give_up) begin
        busy <= 1'b0;
      end else if (win_expire) begin
        windows_used <= windows_used + 1'b1;
      end
    end
  end
endmodule

// File: rtl/oqc_checker.sv
`timescale 1ns/1ps
module oqc_checker #(
  parameter int unsigned WINDOW  = 50000,
  parameter int unsigned THRESH  = 4096,
  parameter int unsigned MAX_WIN = 50,
  localparam int unsigned WUW = oqc_pkg::cnt_width(MAX_WIN),
  localparam int unsigned CW  = oqc_pkg::cnt_width(THRESH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trigger,
  input logic           busy,
  input logic           osc_ok,
  input logic           pass,
  input logic           fail,
  input logic [WUW-1:0] windows_used,
  input logic           win_last,
  input logic           tally_reach,
  input logic [CW-1:0]  edge_count
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (busy && windows_used == WUW'(1)));

  p_ok_is_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    osc_ok |-> pass);

  p_reach_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tally_reach |=> (pass && !busy));

  p_expire_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && win_last && !tally_reach && windows_used < WUW'(MAX_WIN))
      |=> (busy && edge_count == '0));

  p_win_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    windows_used <= WUW'(MAX_WIN));

  p_fail_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (windows_used == WUW'(MAX_WIN) && !busy));

  p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pass || fail));

  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  p_pass_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pass |=> !pass);

  p_fail_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trigger) |=> $stable(windows_used));

  p_tally_below_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_count < CW'(THRESH));
endmodule

bind osc_quality_checker oqc_checker #(
  .WINDOW(WINDOW), .THRESH(THRESH), .MAX_WIN(MAX_WIN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trigger      (trigger),
  .busy         (busy),
  .osc_ok       (osc_ok),
  .pass         (pass),
  .fail         (fail),
  .windows_used (windows_used),
  .win_last     (win_last),
  .tally_reach  (tally_reach),
  .edge_count   (edge_count)
);

// File: tb/osc_quality_checker_test.sv
`timescale 1ns/1ps
module osc_quality_checker_test;
  localparam int CLK_P   = 10;
  localparam int WINDOW  = 400;
  localparam int THRESH  = 50;
  localparam int MAX_WIN = 3;
  localparam int WUW     = $clog2(MAX_WIN + 1);
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_clk = 1'b0;
  logic trigger = 1'b0;
  logic busy, osc_ok, pass, fail;
  logic [WUW-1:0] windows_used;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  osc_run = 1'b0;
  int  osc_p = 40;

  osc_quality_checker #(.WINDOW(WINDOW), .THRESH(THRESH), .MAX_WIN(MAX_WIN)) uut (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .trigger(trigger),
    .busy(busy), .osc_ok(osc_ok), .pass(pass), .fail(fail),
    .windows_used(windows_used)
  );

  always #(CLK_P/2) clk = ~clk;

  always begin
    if (osc_run) begin
      #(osc_p/2) osc_clk = ~osc_clk;
    end else begin
      osc_clk = 1'b0;
      #(CLK_P/2);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Edges per window that a given oscillator period yields.
  function automatic int edges_per_window(input int p);
    return (WINDOW * CLK_P) / p;
  endfunction

  // Periods whose verdict is clear from the rate alone.
  function automatic bit clear_margin(input int p);
    int e = edges_per_window(p);
    return (e >= THRESH + THRESH/4) || (e <= THRESH - THRESH/4);
  endfunction

  function automatic bit expect_pass(input int p);
    return edges_per_window(p) >= THRESH;
  endfunction

  task automatic fire(input string req);
    @(negedge clk) trigger = 1'b1;
    @(negedge clk) trigger = 1'b0;
    check(busy === 1'b1 && windows_used == WUW'(1), req, int'(windows_used), 1);
  endtask

  // Wait for the verdict; busy_cyc counts negedge samples with busy high.
  task automatic await(output bit gp, output bit gf, output bit gk, output int bc);
    bc = 1; gp = 0; gf = 0; gk = 0;
    for (int i = 0; i < MAX_WIN * WINDOW + 50; i++) begin
      @(negedge clk);
      if (pass || fail) begin
        gp = pass; gf = fail; gk = osc_ok;
        break;
      end
      if (busy) bc++;
    end
    check(!(gp && gf), "R6 exclusive", int'(gp) + int'(gf), 1);
    check(!busy, "R6 busy low at verdict", int'(busy), 0);
    @(negedge clk);
    check(!pass && !fail, "R6 one-cycle pulse", int'(pass) + int'(fail), 0);
  endtask

  task automatic expect_fail_run(input string req);
    bit gp, gf, gk; int bc;
    await(gp, gf, gk, bc);
    check(gf && !gp, req, int'(gf), 1);
    check(bc == MAX_WIN * WINDOW, "R5 busy length", bc, MAX_WIN * WINDOW);
    check(windows_used == WUW'(MAX_WIN), "R5 windows_used", int'(windows_used), MAX_WIN);
  endtask

  task automatic expect_pass_run(input string req);
    bit gp, gf, gk; int bc;
    await(gp, gf, gk, bc);
    check(gp && gk && !gf, req, int'(gp) + int'(gk), 2);
    check(bc < WINDOW, "R3 early end", bc, WINDOW - 1);
    check(windows_used == WUW'(1), "R3 first window", int'(windows_used), 1);
  endtask

  initial begin
    int p;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !osc_ok && !pass && !fail && windows_used == '0, "R1 reset",
          int'(busy) + int'(pass) + int'(fail) + int'(windows_used), 0);

    // R10 idle oscillator activity is ignored
    osc_p = 40; osc_run = 1'b1;
    begin
      bit seen = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (busy || pass || fail || osc_ok) seen = 1;
      end
      check(!seen && windows_used == '0, "R10 idle ignored", int'(seen), 0);
    end

    // R3 fast oscillator passes in window one
    fire("R2 start");
    expect_pass_run("R3 pass");

    // R5 stopped oscillator fails after all windows
    osc_run = 1'b0;
    fire("R2 start");
    expect_fail_run("R5 fail");

    // R8 count holds after completion
    repeat (60) @(negedge clk);
    check(windows_used == WUW'(MAX_WIN), "R8 hold", int'(windows_used), MAX_WIN);

    // R9 sub-threshold rate per window fails despite large total
    osc_p = 100; osc_run = 1'b1;
    fire("R2 start");
    expect_fail_run("R9 no carry-over");

    // R7 retrigger midway through window two
    osc_run = 1'b0;
    fire("R2 start");
    repeat (WINDOW + 100) @(negedge clk);
    check(busy && windows_used == WUW'(2), "R4 second window", int'(windows_used), 2);
    fire("R7 restart");
    expect_fail_run("R7 full rerun");

    // Random periods with clear verdicts
    for (int t = 0; t < 10; t++) begin
      do p = 30 + 2 * int'($urandom % 86); while (!clear_margin(p));
      osc_p = p; osc_run = 1'b1;
      repeat (5) @(negedge clk);
      fire("R2 start");
      if (expect_pass(p)) expect_pass_run("R3 random pass");
      else                expect_fail_run("R5 random fail");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule